// File: doc/BRIEF.md
# Margining Command Relay Sequencer

This block runs, in hardware, the relay loop that moves receiver lane-margining commands from a link controller's margining registers to a PHY reached through a request/response mailbox, and carries the PHY's results back. A start-or-change event or a stop event makes it read the latched control word. It then sends a set-control request to the PHY, tagged with this lane's number, and updates the margining status flags.

After a start or change, the sequencer polls without end. Each pass asks the PHY for margin status, writes the error count back to a status register, rewrites the flags and waits a long interval. Only a stop event ends the loop. A stop runs one last set-control, and then clears the PHY-margin-status flag and returns to idle. The mailbox transport and the PHY's own margining lie outside the block. Both wait intervals are parameters given in clock cycles.

Top module: `mrgn_relay_seq`

## Requirements
- R1: After reset the block is idle: no mailbox request, no register read and no register write.
- R2: A start-or-change or stop event causes one control-word read, followed by a set-control request (op 0) that carries the lane number and the fields decoded from the word: enable bit 0, clear bit 1, X bits 8:2, Y bits 14:9, block count bits 22:15.
- R3: A successful set-control is followed by a flag write (select 0) of 0xF (bit 0 software-ready, bit 1 margin-ready, bit 2 PHY margin status, bit 3 error status). The next step comes SHORT_CYC+1 cycles after that write.
- R4: In stop mode, that next step is a flag write of 0xB. The block then returns to idle and issues nothing more.
- R5: Otherwise it sends a get-status request (op 1) with the lane number and zero fields. On success it writes bits 15:0 of the response data with select 1, and in the following cycle writes flags 0xB.
- R6: The next get-status request starts LONG_CYC+1 cycles after each 0xB flag write of the poll loop, and the loop repeats until a stop event.
- R7: A response with the fail flag set or a nonzero return code writes no register. The failed step is retried: a set-control with a fresh control-word read, a get-status directly.
- R8: A request is held with a stable payload until it is accepted. No new request is raised while a response is outstanding.
- R9: An event that arrives during a wait or the poll loop is taken at the next wait or failed response, and moves the block to the matching mode, starting with a new control-word read.
- R10: A start-or-change and a stop in the same cycle count as a stop. Between events, the later one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lane_id | input | LANE_W | Lane number (0 to MAX_LANE) placed in every request |
| evt_start_chg | input | 1 | Pulse: margining start or change |
| evt_stop | input | 1 | Pulse: margining stop |
| reg_rd_en | output | 1 | Read strobe for the control word |
| reg_rd_data | input | 23 | Control word, valid while reg_rd_en is high |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_sel | output | 1 | 0 = status flags, 1 = error count |
| reg_wr_data | output | 16 | Write data |
| mb_req_valid | output | 1 | Mailbox request valid |
| mb_req_ready | input | 1 | Mailbox request accepted |
| mb_req_op | output | 1 | 0 = set-control, 1 = get-status |
| mb_req_lane | output | LANE_W | Lane number |
| mb_req_en | output | 1 | Enable field |
| mb_req_clr | output | 1 | Clear field |
| mb_req_x | output | 7 | X field |
| mb_req_y | output | 6 | Y field |
| mb_req_nblk | output | 8 | Block count field |
| mb_rsp_valid | input | 1 | Response valid, one cycle |
| mb_rsp_fail | input | 1 | Transport failure |
| mb_rsp_code | input | 8 | Return code, nonzero is an error |
| mb_rsp_data | input | 32 | Response data |

## Verification
The bound checker watches the mailbox handshake on every cycle. It checks that a waiting request holds its payload and that no second request is raised while one is outstanding. It also checks that every set-control follows a control-word read, that flag writes carry only 0xF or 0xB, that no register is written after a failed response, and that each error-count write matches the previous successful response. The order of steps, the wait lengths, the end of the loop on stop, the retries, the priority between events and preemption during the poll loop depend on sequences of many steps. Only the directed scenarios show these, and they do so by logging each read, request and write with its cycle number.

// File: rtl/mrgn_relay_seq.sv
module mrgn_relay_seq #(
  parameter int MAX_LANE  = 24,
  parameter int LANE_W    = $clog2(MAX_LANE + 1),
  parameter int SHORT_CYC = 1000,
  parameter int LONG_CYC  = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_id,
  input  logic              evt_start_chg,
  input  logic              evt_stop,
  output logic              reg_rd_en,
  input  logic [22:0]       reg_rd_data,
  output logic              reg_wr_en,
  output logic              reg_wr_sel,
  output logic [15:0]       reg_wr_data,
  output logic              mb_req_valid,
  input  logic              mb_req_ready,
  output logic              mb_req_op,
  output logic [LANE_W-1:0] mb_req_lane,
  output logic              mb_req_en,
  output logic              mb_req_clr,
  output logic [6:0]        mb_req_x,
  output logic [5:0]        mb_req_y,
  output logic [7:0]        mb_req_nblk,
  input  logic              mb_rsp_valid,
  input  logic              mb_rsp_fail,
  input  logic [7:0]        mb_rsp_code,
  input  logic [31:0]       mb_rsp_data
);
  localparam int MAXW  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [3:0] FLG_ALL  = 4'hF;
  localparam logic [3:0] FLG_HOLD = 4'hB;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_SET_REQ, S_SET_RSP, S_SET_FLG, S_WAIT_S, S_STOP_FLG,
    S_GET_REQ, S_GET_RSP, S_WR_ERR, S_GET_FLG, S_WAIT_L
  } state_t;

  state_t           state, nxt;
  logic             pend_v, pend_stop, mode_stop;
  logic [22:0]      ctrl_q;
  logic [15:0]      err_q;
  logic [CNT_W-1:0] cnt;

  wire evt      = evt_start_chg | evt_stop;
  wire rsp_ok   = mb_rsp_valid & ~mb_rsp_fail & (mb_rsp_code == 8'd0);
  wire rsp_bad  = mb_rsp_valid & ~rsp_ok;
  wire at_wait  = (state == S_WAIT_S) || (state == S_WAIT_L);
  wire at_rsp   = (state == S_SET_RSP) || (state == S_GET_RSP);
  wire take     = pend_v & ((state == S_IDLE) | at_wait | (at_rsp & rsp_bad));
  wire [CNT_W-1:0] lim = (state == S_WAIT_S) ? CNT_W'(SHORT_CYC - 1) : CNT_W'(LONG_CYC - 1);
  wire wait_done = (cnt == lim);

  always_comb begin
    nxt = state;
    if (take) nxt = S_RD;
    else begin
      case (state)
        S_IDLE:     nxt = S_IDLE;
        S_RD:       nxt = S_SET_REQ;
        S_SET_REQ:  if (mb_req_ready) nxt = S_SET_RSP;
        S_SET_RSP:  if (rsp_ok) nxt = S_SET_FLG; else if (rsp_bad) nxt = S_RD;
        S_SET_FLG:  nxt = S_WAIT_S;
        S_WAIT_S:   if (wait_done) nxt = mode_stop ? S_STOP_FLG : S_GET_REQ;
        S_STOP_FLG: nxt = S_IDLE;
        S_GET_REQ:  if (mb_req_ready) nxt = S_GET_RSP;
        S_GET_RSP:  if (rsp_ok) nxt = S_WR_ERR; else if (rsp_bad) nxt = S_GET_REQ;
        S_WR_ERR:   nxt = S_GET_FLG;
        S_GET_FLG:  nxt = S_WAIT_L;
        S_WAIT_L:   if (wait_done) nxt = S_GET_REQ;
        default:    nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pend_v    <= 1'b0;
      pend_stop <= 1'b0;
      mode_stop <= 1'b0;
      ctrl_q    <= '0;
      err_q     <= '0;
      cnt       <= '0;
    end else begin
      state <= nxt;
      if (evt) begin
        pend_v    <= 1'b1;
        pend_stop <= evt_stop;
      end else if (take) begin
        pend_v <= 1'b0;
      end
      if (take) mode_stop <= pend_stop;
      if (state == S_RD) ctrl_q <= reg_rd_data;
      if (state == S_GET_RSP && rsp_ok) err_q <= mb_rsp_data[15:0];
      cnt <= (at_wait && nxt == state) ? cnt + 1'b1 : '0;
    end
  end

  wire is_set = (state == S_SET_REQ);

  assign reg_rd_en    = (state == S_RD);
  assign mb_req_valid = is_set || (state == S_GET_REQ);
  assign mb_req_op    = (state == S_GET_REQ);
  assign mb_req_lane  = lane_id;
  assign mb_req_en    = is_set & ctrl_q[0];
  assign mb_req_clr   = is_set & ctrl_q[1];
  assign mb_req_x     = is_set ? ctrl_q[8:2]   : 7'd0;
  assign mb_req_y     = is_set ? ctrl_q[14:9]  : 6'd0;
  assign mb_req_nblk  = is_set ? ctrl_q[22:15] : 8'd0;

  assign reg_wr_en   = (state == S_SET_FLG) || (state == S_STOP_FLG) ||
                       (state == S_WR_ERR)  || (state == S_GET_FLG);
  assign reg_wr_sel  = (state == S_WR_ERR);
  assign reg_wr_data = (state == S_WR_ERR)  ? err_q :
                       (state == S_SET_FLG) ? {12'd0, FLG_ALL} : {12'd0, FLG_HOLD};
endmodule

// File: rtl/mrgn_relay_seq_chk.sv
module mrgn_relay_seq_chk #(
  parameter int LANE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd_en,
  input logic              reg_wr_en,
  input logic              reg_wr_sel,
  input logic [15:0]       reg_wr_data,
  input logic              mb_req_valid,
  input logic              mb_req_ready,
  input logic              mb_req_op,
  input logic [LANE_W-1:0] mb_req_lane,
  input logic              mb_req_en,
  input logic              mb_req_clr,
  input logic [6:0]        mb_req_x,
  input logic [5:0]        mb_req_y,
  input logic [7:0]        mb_req_nblk,
  input logic              mb_rsp_valid,
  input logic              mb_rsp_fail,
  input logic [7:0]        mb_rsp_code,
  input logic [31:0]       mb_rsp_data
);
  logic outstanding, rd_seen;
  wire ok = mb_rsp_valid & ~mb_rsp_fail & (mb_rsp_code == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      rd_seen     <= 1'b0;
    end else begin
      if (mb_req_valid && mb_req_ready) outstanding <= 1'b1;
      else if (mb_rsp_valid) outstanding <= 1'b0;
      if (reg_rd_en) rd_seen <= 1'b1;
      else if (mb_req_valid && mb_req_ready && !mb_req_op) rd_seen <= 1'b0;
    end
  end

  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && !mb_req_ready |=> mb_req_valid &&
      $stable({mb_req_op, mb_req_lane, mb_req_en, mb_req_clr, mb_req_x, mb_req_y, mb_req_nblk}));

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mb_req_valid);

  a_r2_read_before_set: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && !mb_req_op |-> rd_seen);

  a_r3_flag_values: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && !reg_wr_sel |-> (reg_wr_data == 16'h000F) || (reg_wr_data == 16'h000B));

  a_r7_no_write_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rsp_valid && !ok |=> !reg_wr_en);

  a_r5_errcnt_from_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_wr_sel |-> $past(ok) && (reg_wr_data == $past(mb_rsp_data[15:0])));
endmodule

bind mrgn_relay_seq mrgn_relay_seq_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/mrgn_relay_seq_tb.sv
module mrgn_relay_seq_tb;
  localparam int S = 4;
  localparam int L = 12;
  localparam int K_RD = 1, K_SET = 2, K_GET = 3, K_FLG = 4, K_ERR = 5;

  logic clk = 0, rst_n = 0;
  logic [4:0] lane_id = 5'd17;
  logic evt_start_chg = 0, evt_stop = 0;
  logic reg_rd_en, reg_wr_en, reg_wr_sel;
  logic [22:0] reg_rd_data = '0;
  logic [15:0] reg_wr_data;
  logic mb_req_valid, mb_req_ready = 0, mb_req_op, mb_req_en, mb_req_clr;
  logic [4:0] mb_req_lane;
  logic [6:0] mb_req_x;
  logic [5:0] mb_req_y;
  logic [7:0] mb_req_nblk;
  logic mb_rsp_valid = 0, mb_rsp_fail = 0;
  logic [7:0] mb_rsp_code = 0;
  logic [31:0] mb_rsp_data = 0;

  mrgn_relay_seq #(.SHORT_CYC(S), .LONG_CYC(L)) u_dut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int lk[64], lc[64];
  logic [31:0] lv[64];
  int ln = 0;
  int hs = 0, hs_op = 0, busy = 0, lat = 0, stall = 0, inj_set = 0, inj_get = 0, gcount = 0;
  int hold_viol = 0, ovl = 0, prev_wait = 0;
  logic [31:0] prev_pl = 0;

  wire [31:0] pl = {4'd0, mb_req_lane, mb_req_nblk, mb_req_y, mb_req_x, mb_req_clr, mb_req_en};

  task automatic logit(int k, logic [31:0] v);
    if (ln < 64) begin lk[ln] = k; lv[ln] = v; lc[ln] = cyc; ln++; end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (prev_wait != 0 && mb_req_valid && pl != prev_pl) hold_viol++;
    if (mb_req_valid && busy != 0) ovl++;
    prev_wait = (mb_req_valid && !mb_req_ready) ? 1 : 0;
    prev_pl = pl;
    if (reg_rd_en) logit(K_RD, 0);
    if (mb_req_valid && mb_req_ready) begin
      logit(mb_req_op ? K_GET : K_SET, pl);
      hs = 1; hs_op = mb_req_op ? 1 : 0;
    end
    if (reg_wr_en) logit(reg_wr_sel ? K_ERR : K_FLG, {16'd0, reg_wr_data});
  end

  always @(posedge clk) begin
    #1;
    mb_rsp_valid = 0; mb_rsp_fail = 0; mb_rsp_code = 0;
    if (busy != 0) begin
      if (lat == 0) begin
        mb_rsp_valid = 1; busy = 0;
        if (hs_op == 0 && inj_set > 0) begin
          if (inj_set % 2 == 0) mb_rsp_fail = 1; else mb_rsp_code = 8'd3;
          inj_set--;
        end
        if (hs_op == 1) begin
          gcount++;
          mb_rsp_data = {16'hBEEF, 16'h4000 + 16'(gcount)};
          if (inj_get > 0) begin mb_rsp_code = 8'd5; inj_get--; end
        end
      end else lat--;
    end
    if (hs != 0) begin busy = 1; lat = 1; hs = 0; end
    if (mb_req_valid && busy == 0) begin
      if (stall > 0) begin stall--; mb_req_ready = 0; end else mb_req_ready = 1;
    end else mb_req_ready = 0;
  end

  always @(posedge clk) if (cyc > 100000) begin
    nfail++; nchk++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cyc);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic chk_k(int i, int k, string req);
    chk(i < ln && lk[i] == k, req, (i < ln) ? lk[i] : -1, k);
  endtask

  task automatic clear_log(); ln = 0; gcount = 0; endtask

  task automatic pulse(bit st, bit sp);
    @(posedge clk); #2; evt_start_chg = st; evt_stop = sp;
    @(posedge clk); #2; evt_start_chg = 0; evt_stop = 0;
  endtask

  task automatic wait_n(int n, string req);
    for (int i = 0; i < 2000 && ln < n; i++) @(negedge clk);
    chk(ln >= n, req, ln, n);
  endtask

  function automatic logic [22:0] mkw(bit en, bit clr, logic [6:0] x, logic [5:0] y, logic [7:0] nb);
    return {nb, y, x, clr, en};
  endfunction

  task automatic wait_hold_flag();
    clear_log();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (ln > 0 && lk[ln-1] == K_FLG && lv[ln-1] == 32'hB) break;
    end
  endtask

  task automatic stop_loop(string req);
    wait_hold_flag();
    clear_log();
    pulse(0, 1);
    wait_n(4, req);
    repeat (40) @(negedge clk);
    chk_k(0, K_RD, req); chk_k(1, K_SET, req); chk_k(2, K_FLG, req); chk_k(3, K_FLG, req);
    chk(ln == 4 && lv[3] == 32'hB, req, ln, 4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!mb_req_valid && !reg_wr_en && !reg_rd_en, "R1 reset idle",
        {mb_req_valid, reg_wr_en, reg_rd_en}, 0);
  endtask

  task automatic t_start_loop();
    logic [22:0] w = mkw(1, 0, 7'h55, 6'h2A, 8'hC3);
    reg_rd_data = w; clear_log();
    pulse(1, 0);
    wait_n(9, "R6 loop entries");
    chk_k(0, K_RD, "R2 read first");
    chk_k(1, K_SET, "R2 set request");
    chk(lv[1] == {4'd0, 5'd17, w}, "R2 set payload", lv[1], {4'd0, 5'd17, w});
    chk(lv[2] == 32'hF, "R3 flags all", lv[2], 32'hF);
    chk_k(3, K_GET, "R5 get request");
    chk(lc[3] - lc[2] == S + 1, "R3 short wait", lc[3] - lc[2], S + 1);
    chk(lv[3] == {4'd0, 5'd17, 23'd0}, "R5 get payload", lv[3], {4'd0, 5'd17, 23'd0});
    chk_k(4, K_ERR, "R5 err write");
    chk(lv[4] == 32'h4001, "R5 err low16", lv[4], 32'h4001);
    chk(lk[5] == K_FLG && lv[5] == 32'hB, "R5 hold flags", lv[5], 32'hB);
    chk_k(6, K_GET, "R6 repeat get");
    chk(lc[6] - lc[5] == L + 1, "R6 long wait", lc[6] - lc[5], L + 1);
    chk(lv[7] == 32'h4002, "R6 second err", lv[7], 32'h4002);
    stop_loop("R4 stop ends loop");
    chk(!mb_req_valid && !reg_wr_en, "R4 idle after stop", mb_req_valid, 0);
  endtask

  task automatic t_stop_gap();
    reg_rd_data = mkw(0, 1, 7'h01, 6'h3F, 8'h10); clear_log();
    pulse(0, 1);
    wait_n(4, "R4 stop entries");
    chk(lc[3] - lc[2] == S + 1 && lv[3] == 32'hB, "R4 stop after short wait", lc[3] - lc[2], S + 1);
    chk(lv[1] == {4'd0, 5'd17, mkw(0, 1, 7'h01, 6'h3F, 8'h10)}, "R2 stop payload", lv[1],
        {4'd0, 5'd17, mkw(0, 1, 7'h01, 6'h3F, 8'h10)});
    repeat (30) @(negedge clk);
  endtask

  task automatic t_set_retry();
    reg_rd_data = mkw(1, 1, 7'h7F, 6'h00, 8'hFF); inj_set = 2; clear_log();
    pulse(0, 1);
    wait_n(8, "R7 set retry entries");
    chk_k(2, K_RD, "R7 reread after fail"); chk_k(3, K_SET, "R7 set retry");
    chk_k(4, K_RD, "R7 reread after code"); chk_k(5, K_SET, "R7 set retry 2");
    chk(lk[6] == K_FLG && lv[6] == 32'hF, "R7 flags only after success", lv[6], 32'hF);
    repeat (30) @(negedge clk);
    chk(ln == 8, "R7 stop completes", ln, 8);
  endtask

  task automatic t_get_retry();
    reg_rd_data = mkw(1, 0, 7'h02, 6'h03, 8'h04); inj_get = 1; clear_log();
    pulse(1, 0);
    wait_n(7, "R7 get retry entries");
    chk_k(3, K_GET, "R7 first get"); chk_k(4, K_GET, "R7 get retried");
    chk(lk[5] == K_ERR && lv[5] == 32'h4002, "R7 err from retry", lv[5], 32'h4002);
    stop_loop("R9 stop preempts poll");
  endtask

  task automatic t_hold();
    hold_viol = 0; ovl = 0; stall = 3;
    reg_rd_data = mkw(1, 0, 7'h11, 6'h22, 8'h33); clear_log();
    pulse(1, 0);
    wait_n(4, "R8 stalled request");
    chk(hold_viol == 0, "R8 payload held", hold_viol, 0);
    chk(lv[1] == {4'd0, 5'd17, mkw(1, 0, 7'h11, 6'h22, 8'h33)}, "R8 payload after stall", lv[1],
        {4'd0, 5'd17, mkw(1, 0, 7'h11, 6'h22, 8'h33)});
    stop_loop("R8 stop");
    chk(ovl == 0, "R8 one outstanding", ovl, 0);
  endtask

  task automatic t_both();
    clear_log();
    pulse(1, 1);
    wait_n(4, "R10 both events");
    repeat (40) @(negedge clk);
    chk(ln == 4 && lk[3] == K_FLG && lv[3] == 32'hB, "R10 stop wins", ln, 4);
  endtask

  task automatic t_preempt_start();
    logic [22:0] w3 = mkw(0, 0, 7'h6A, 6'h15, 8'h81);
    reg_rd_data = mkw(1, 0, 7'h01, 6'h01, 8'h01); clear_log();
    pulse(1, 0);
    wait_hold_flag();
    reg_rd_data = w3; clear_log();
    pulse(1, 0);
    wait_n(3, "R9 change entries");
    chk_k(0, K_RD, "R9 reread on change");
    chk(lk[1] == K_SET && lv[1] == {4'd0, 5'd17, w3}, "R9 new payload", lv[1], {4'd0, 5'd17, w3});
    chk(lv[2] == 32'hF, "R9 flags after change", lv[2], 32'hF);
    stop_loop("R9 stop");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_start_loop();
    t_stop_gap();
    t_set_retry();
    t_get_retry();
    t_hold();
    t_both();
    t_preempt_start();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule